// File: doc/BRIEF.md
# NAND Flash Address-Window Bus Front End

This block connects a simple host access port to a raw 8-bit NAND flash bus. Each host access lands at an offset inside a memory window, and the offset alone decides what kind of flash bus cycle is issued. The base offset carries data bytes. A second offset carries command bytes, with the command latch raised. A third offset carries address bytes, with the address latch raised. The host never programs a cycle type in a register.

A small control register holds two sticky bits. One enables the window; the other keeps the chip enable asserted across any number of bus cycles, which is how multi-byte command, address and data sequences are framed. The flash ready/busy line passes through a synchronizer and can be read as a status bit.

Every accepted access runs a fixed strobe sequence of setup, pulse and hold phases, with the lengths set by parameters. The host port shows ready low for the whole sequence and accepts nothing new until it ends.

Top module: `nand_win_fe`

## Requirements
- R1: After reset, ready_o=1, nand_we_no=1, nand_re_no=1, nand_ce_no=1, nand_cle_o=0, nand_ale_o=0, nand_io_oe_o=0, rdata_o=0 and csr_rdata_o=0.
- R2: A write at offset 0x00000 with the window enabled is a data cycle: CLE=0, ALE=0, nand_io_oe_o=1 and nand_io_o=wdata_i for the whole sequence, and nand_we_no pulses low.
- R3: A write at offset 0x08000 is a command cycle: CLE=1 and ALE=0 for the whole sequence, and nand_we_no pulses low.
- R4: A write at offset 0x10000 is an address cycle: ALE=1 and CLE=0 for the whole sequence, and nand_we_no pulses low.
- R5: A read at offset 0x00000 pulses nand_re_no low, keeps nand_we_no high and nand_io_oe_o low, and afterwards rdata_o holds nand_io_i as sampled in the last pulse cycle.
- R6: An accepted access (req_i and ready_o at a clock edge) holds ready_o low for exactly SETUP_CYC+PULSE_CYC+HOLD_CYC cycles (default 1+2+1). The strobe goes low after SETUP_CYC of those cycles and stays low for exactly PULSE_CYC cycles.
- R7: Control register bit 1 (chip enable) drives nand_ce_no low while set. Changes reach nand_ce_no only while the sequencer is idle, and nand_ce_no never changes during a sequence.
- R8: nand_cle_o and nand_ale_o are never both high, and at most one of nand_we_no and nand_re_no is low.
- R9: An access is ignored if the window-enable bit (control bit 0) is clear, if its offset is not one of the three offsets, or if it is a read at the command or address offset. An ignored access produces no strobe, keeps ready_o high, and sets rdata_o to 0.
- R10: csr_rdata_o bit 2 shows nand_rb_i (1 = ready) after a two-flop synchronizer. A change on nand_rb_i appears at the second rising edge after it.
- R11: csr_we_i writes csr_wdata_i[1:0] into control bits [1:0], and csr_rdata_o[1:0] reads them back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Offset inside the window |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Last read byte, or 0 after an ignored access |
| ready_o | output | 1 | Idle; an access is accepted when req_i is high |
| csr_we_i | input | 1 | Control register write strobe |
| csr_wdata_i | input | 2 | Control bits: [0] window enable, [1] chip enable |
| csr_rdata_o | output | 3 | [0] window enable, [1] chip enable, [2] synchronized ready/busy |
| nand_io_i | input | 8 | Flash data bus in |
| nand_io_o | output | 8 | Flash data bus out |
| nand_io_oe_o | output | 1 | Flash data bus output enable |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_rb_i | input | 1 | Flash ready/busy, 1 = ready |

## Verification
A sequencer stuck in or skipping a phase shows up on the first access as a wrong ready-low length or a wrong strobe width and offset. Both are counted cycle by cycle. A wrongly latched cycle kind shows as the wrong latch line during that same access, and a bad read capture shows in rdata_o as soon as ready_o returns. A chip enable or status path that is out of step shows within two cycles of a control write or a ready/busy change.

// File: rtl/nand_win_pkg.sv
`timescale 1ns/1ps
package nand_win_pkg;
  typedef enum logic [1:0] {
    CYC_DATA = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;
endpackage

// File: rtl/nand_win_sync.sv
`timescale 1ns/1ps
module nand_win_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/nand_win_decode.sv
`timescale 1ns/1ps
module nand_win_decode
  import nand_win_pkg::*;
#(
  parameter int          AW       = 17,
  parameter logic [AW-1:0] DATA_OFF = '0,
  parameter logic [AW-1:0] CMD_OFF  = AW'(32'h08000),
  parameter logic [AW-1:0] ADDR_OFF = AW'(32'h10000)
) (
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          valid_o,
  output cyc_kind_e     kind_o
);
  logic hit_data, hit_cmd, hit_addr;

  assign hit_data = (addr_i == DATA_OFF);
  assign hit_cmd  = (addr_i == CMD_OFF);
  assign hit_addr = (addr_i == ADDR_OFF);

  // command/address windows are write-only
  assign valid_o = en_i & (hit_data | (we_i & (hit_cmd | hit_addr)));

  always_comb begin
    kind_o = CYC_DATA;
    if (hit_cmd)       kind_o = CYC_CMD;
    else if (hit_addr) kind_o = CYC_ADDR;
  end
endmodule

// File: rtl/nand_win_timer.sv
`timescale 1ns/1ps
module nand_win_timer
  import nand_win_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic strobe_o,
  output logic sample_o
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_SETUP;
          cnt_q <= CW'(SETUP_CYC - 1);
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_PULSE;
          cnt_q <= CW'(PULSE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PULSE: if (last) begin
          ph_q  <= PH_HOLD;
          cnt_q <= CW'(HOLD_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o   = (ph_q != PH_IDLE);
  assign strobe_o = (ph_q == PH_PULSE);
  assign sample_o = (ph_q == PH_PULSE) && last;
endmodule

// File: rtl/nand_win_fe.sv
`timescale 1ns/1ps
module nand_win_fe
  import nand_win_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int SYNC_STG  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  input  logic          csr_we_i,
  input  logic [1:0]    csr_wdata_i,
  output logic [2:0]    csr_rdata_o,
  input  logic [DW-1:0] nand_io_i,
  output logic [DW-1:0] nand_io_o,
  output logic          nand_io_oe_o,
  output logic          nand_cle_o,
  output logic          nand_ale_o,
  output logic          nand_we_no,
  output logic          nand_re_no,
  output logic          nand_ce_no,
  input  logic          nand_rb_i
);
  logic          win_en_q, ce_en_q, ce_q;
  logic          dec_valid, accept, start;
  cyc_kind_e     dec_kind, kind_q;
  logic          rd_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          busy, strobe, sample, rb_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_en_q <= 1'b0;
      ce_en_q  <= 1'b0;
    end else if (csr_we_i) begin
      win_en_q <= csr_wdata_i[0];
      ce_en_q  <= csr_wdata_i[1];
    end
  end

  nand_win_decode #(.AW(AW)) u_dec (
    .en_i    (win_en_q),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .valid_o (dec_valid),
    .kind_o  (dec_kind)
  );

  assign accept = req_i & ~busy;
  assign start  = accept & dec_valid;

  nand_win_timer #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .busy_o   (busy),
    .strobe_o (strobe),
    .sample_o (sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= CYC_DATA;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      ce_q    <= 1'b0;
    end else begin
      if (!busy) ce_q <= ce_en_q;  // chip enable moves only between sequences
      if (start) begin
        kind_q  <= dec_kind;
        rd_q    <= ~we_i;
        wdata_q <= wdata_i;
      end else if (accept) begin
        rdata_q <= '0;
      end
      if (sample && rd_q) rdata_q <= nand_io_i;
    end
  end

  nand_win_sync #(.STAGES(SYNC_STG)) u_rb_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nand_rb_i),
    .q_o    (rb_sync)
  );

  assign ready_o      = ~busy;
  assign rdata_o      = rdata_q;
  assign csr_rdata_o  = {rb_sync, ce_en_q, win_en_q};
  assign nand_io_o    = wdata_q;
  assign nand_io_oe_o = busy & ~rd_q;
  assign nand_cle_o   = busy & (kind_q == CYC_CMD);
  assign nand_ale_o   = busy & (kind_q == CYC_ADDR);
  assign nand_we_no   = ~(strobe & ~rd_q);
  assign nand_re_no   = ~(strobe & rd_q);
  assign nand_ce_no   = ~ce_q;
endmodule

// File: rtl/nand_win_chk.sv
`timescale 1ns/1ps
module nand_win_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic nand_io_oe_o,
  input logic nand_cle_o,
  input logic nand_ale_o,
  input logic nand_we_no,
  input logic nand_re_no,
  input logic nand_ce_no
);
  a_r8_no_ale_cle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  a_r6_strobe_in_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !ready_o);

  a_r7_ce_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (ready_o || $stable(nand_ce_no)));

  a_r5_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_io_oe_o);

  a_r9_latch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!nand_cle_o && !nand_ale_o && !nand_io_oe_o));
endmodule

bind nand_win_fe nand_win_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .nand_io_oe_o (nand_io_oe_o),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_ce_no   (nand_ce_no)
);

// File: tb/tb_nand_win_fe.sv
`timescale 1ns/1ps
module tb_nand_win_fe;
  localparam int S = 1, P = 2, H = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, csr_we = 0, rb = 0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0, io_in = '0;
  logic [1:0]  csr_wd = '0;
  logic [7:0]  rdata, io_out;
  logic [2:0]  csr_rd;
  logic        ready, oe, cle, ale, we_n, re_n, ce_n;

  int checks = 0, failures = 0;
  logic ce_bit = 0, en_bit = 0;

  always #5 clk = ~clk;

  nand_win_fe dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .csr_we_i(csr_we), .csr_wdata_i(csr_wd), .csr_rdata_o(csr_rd),
    .nand_io_i(io_in), .nand_io_o(io_out), .nand_io_oe_o(oe),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_ce_no(ce_n), .nand_rb_i(rb)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  // 0 ignored, 1 data, 2 command, 3 address
  function automatic int classify(input logic [16:0] a, input logic w, input logic en);
    if (!en) return 0;
    if (a == 17'h00000) return 1;
    if (w && a == 17'h08000) return 2;
    if (w && a == 17'h10000) return 3;
    return 0;
  endfunction

  task automatic csr_write(input logic [1:0] v);
    @(negedge clk); csr_we = 1; csr_wd = v;
    @(negedge clk); csr_we = 0;
    en_bit = v[0]; ce_bit = v[1];
    chk(csr_rd[1:0] == v, "R11 csr readback", csr_rd[1:0], v);
    @(negedge clk);
    chk(ce_n == ~ce_bit, "R7 ce follows bit", ce_n, ~ce_bit);
  endtask

  task automatic access(input logic [16:0] a, input logic w, input logic [7:0] d,
                        input logic [7:0] flash);
    int k, busy_n, stb_n, first_stb;
    bit bad_cle, bad_ale, bad_oe, bad_io, bad_ce, wrong_stb;
    string tag;
    k = classify(a, w, en_bit);
    tag = (k == 0) ? "R9" : (k == 2) ? "R3" : (k == 3) ? "R4" : (w ? "R2" : "R5");
    @(negedge clk); req = 1; addr = a; we = w; wdata = d; io_in = flash;
    @(negedge clk); req = 0;
    if (k == 0) begin
      chk(ready == 1'b1, "R9 ignored keeps ready", ready, 1);
      chk(we_n && re_n, "R9 ignored no strobe", {we_n, re_n}, 3);
      chk(rdata == 8'h00, "R9 ignored reads zero", rdata, 0);
      return;
    end
    busy_n = 0; stb_n = 0; first_stb = -1;
    bad_cle = 0; bad_ale = 0; bad_oe = 0; bad_io = 0; bad_ce = 0; wrong_stb = 0;
    while (!ready && busy_n < 64) begin
      if (cle != (k == 2)) bad_cle = 1;
      if (ale != (k == 3)) bad_ale = 1;
      if (oe != w) bad_oe = 1;
      if (w && io_out != d) bad_io = 1;
      if (ce_n != ~ce_bit) bad_ce = 1;
      if ((w && !re_n) || (!w && !we_n)) wrong_stb = 1;
      if ((w && !we_n) || (!w && !re_n)) begin
        if (first_stb < 0) first_stb = busy_n;
        stb_n++;
      end
      busy_n++;
      @(negedge clk);
    end
    chk(busy_n == S + P + H, "R6 ready low length", busy_n, S + P + H);
    chk(stb_n == P, "R6 strobe width", stb_n, P);
    chk(first_stb == S, "R6 strobe offset", first_stb, S);
    chk(!bad_cle, {tag, " cle level"}, bad_cle, 0);
    chk(!bad_ale, {tag, " ale level"}, bad_ale, 0);
    chk(!bad_oe && !bad_io, {tag, " bus drive"}, {bad_oe, bad_io}, 0);
    chk(!wrong_stb, "R5 strobe kind", wrong_stb, 0);
    chk(!bad_ce, "R7 ce stable in sequence", bad_ce, 0);
    if (!w) chk(rdata == flash, "R5 read data", rdata, flash);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    logic [16:0] offs [4];
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    offs[0] = 17'h00000; offs[1] = 17'h08000; offs[2] = 17'h10000; offs[3] = 17'h00001;

    #23; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ready && we_n && re_n && ce_n, "R1 idle strobes", {ready, we_n, re_n, ce_n}, 4'hf);
    chk(!cle && !ale && !oe, "R1 latches low", {cle, ale, oe}, 0);
    chk(rdata == 0 && csr_rd == 0, "R1 data and csr", {rdata, csr_rd}, 0);

    // R9 disabled window
    access(17'h00000, 1, 8'hA5, 8'h00);
    access(17'h08000, 1, 8'h90, 8'h00);

    csr_write(2'b11);
    access(17'h08000, 1, 8'h70, 8'h00);       // R3
    access(17'h10000, 1, 8'h12, 8'h00);       // R4
    access(17'h00000, 1, 8'h3C, 8'h00);       // R2
    access(17'h00000, 0, 8'h00, 8'hC3);       // R5
    access(17'h08000, 0, 8'h00, 8'hFF);       // R9 read at command offset
    access(17'h10000, 0, 8'h00, 8'hFF);       // R9 read at address offset
    access(17'h04000, 1, 8'h55, 8'hFF);       // R9 unknown offset
    access(17'h1FFFF, 0, 8'h55, 8'hFF);       // R9 unknown offset read

    // R7 CE clear takes effect between sequences
    csr_write(2'b01);
    access(17'h00000, 1, 8'h81, 8'h00);

    // R10 ready/busy synchronizer latency
    @(negedge clk); rb = 1;
    @(negedge clk);
    chk(csr_rd[2] == 1'b0, "R10 rb not yet visible", csr_rd[2], 0);
    @(negedge clk);
    chk(csr_rd[2] == 1'b1, "R10 rb visible", csr_rd[2], 1);
    @(negedge clk); rb = 0;
    @(negedge clk); @(negedge clk);
    chk(csr_rd[2] == 1'b0, "R10 rb busy", csr_rd[2], 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) csr_write(2'($urandom_range(0, 3)));
      a = offs[$urandom_range(0, 3)];
      if (a == 17'h00001) a = 17'($urandom);
      access(a, 1'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule